// File: doc/BRIEF.md
# Multimode Up/Down General-Purpose Timer

This block is a 16-bit timer/counter with four count sources. In timer mode it advances once per period of a prescaled system clock. In gated mode it advances on the same prescaled ticks, but only while an external gate input sits at its selected active level. In event mode it advances on chosen edges of that same external input. In chain mode it advances on single-cycle wrap pulses from a neighbouring timer, which is how two timers are concatenated into a wider one.

The count direction comes from a software bit. When external direction control is enabled, that bit is XORed with a synchronized external direction pin. Each time the count wraps, the block issues a one-cycle wrap pulse, in both directions. The pulse can drive the chain input of the next timer.

Software sees two locations through a simple register port:
- address 0 is the control word;
- address 1 is the count, and writing it loads a new value.

Top module: `updn_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 and the wrap output is low.
- R2: In timer mode (control bits [1:0]=0) with run (bit 5) set, the count advances once every 8·2^S system clocks, where S is control bits [4:2]. The first step lands 8·2^S clocks after the write that sets run.
- R3: With run clear, the count holds its value indefinitely.
- R4: In gated mode (bits [1:0]=1), prescaled ticks are counted only while the synchronized gate input is active. The gate is active-high when bit 8 is 0 and active-low when bit 8 is 1.
- R5: In event mode (bits [1:0]=2), the count advances once per edge of the external input. Bit 9 enables rising edges and bit 10 enables falling edges; with both clear, nothing is counted.
- R6: The count moves down when (bit 6) XOR (bit 7 AND synchronized direction pin) is 1, and up otherwise. With bit 7 clear, the pin has no effect.
- R7: A step upward from 0xFFFF gives 0 and a wrap pulse exactly one cycle wide, in the cycle after the step.
- R8: A step downward from 0 gives 0xFFFF and a one-cycle wrap pulse.
- R9: In chain mode (bits [1:0]=3), the count advances once for each clock in which the chain input is high, and at no other time.
- R10: A write to address 1 loads the count with the written data, and the value reads back at address 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 count) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| evt_in | input | 1 | External gate level / count event input (asynchronous) |
| dir_in | input | 1 | External direction input (asynchronous) |
| chain_in | input | 1 | Wrap pulse from a neighbouring timer (synchronous) |
| wrap_pulse | output | 1 | One-cycle pulse on count wrap in either direction |

## Verification
Most internal faults show up directly at the ports. A wrong prescaler phase or a wrong divide setting appears as a count that is off by one when read exactly at a tick boundary, within one prescaler period. A wrong direction term or a wrong edge or gate selection shows as a count off by the whole test window. A missed or extra wrap shows in the running total of wrap pulses as soon as the count crosses 0xFFFF/0. The bench reads the count at exact cycle offsets from the write that starts it, so a fault shows within the same test window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = 3;
  localparam int PS_BASE = 3;
  localparam int PS_W    = PS_BASE + (1 << SEL_W) - 1;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_GATED = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_CHAIN = 2'd3
  } mode_e;

  typedef struct packed {
    logic [4:0]       rsvd;
    logic             fall_en;
    logic             rise_en;
    logic             gate_low;
    logic             xdir_en;
    logic             down;
    logic             run;
    logic [SEL_W-1:0] ps_sel;
    mode_e            mode;
  } ctrl_t;

  // low-bit mask whose all-ones state marks a prescaler tick
  function automatic logic [PS_W-1:0] ps_mask(input logic [SEL_W-1:0] sel);
    int m;
    m = (1 << (PS_BASE + int'(sel))) - 1;
    return m[PS_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cnt,
                                                  input logic down);
    return down ? cnt - 1'b1 : cnt + 1'b1;
  endfunction

  function automatic logic at_wrap(input logic [CNT_W-1:0] cnt, input logic down);
    return down ? (cnt == '0) : (cnt == '1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int P_W = PS_W,
  parameter int S_W = SEL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [S_W-1:0] sel,
  output logic           tick
);
  logic [P_W-1:0] div_q;
  logic [P_W-1:0] mask;

  assign mask = ps_mask(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign tick = run && ((div_q & mask) == mask);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  mode_e          mode,
  input  logic           run,
  input  logic           sw_down,
  input  logic           xdir_en,
  input  logic           gate_low,
  input  logic           rise_en,
  input  logic           fall_en,
  input  logic           tick,
  input  logic           evt_lvl,
  input  logic           xdir_lvl,
  input  logic           chain_in,
  input  logic           load,
  input  logic [C_W-1:0] load_val,
  output logic [C_W-1:0] count_q,
  output logic           wrap_q
);
  logic evt_prev_q;
  logic ev_rise, ev_fall;
  logic gate_open;
  logic down_eff;
  logic step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_prev_q <= 1'b0;
    else        evt_prev_q <= evt_lvl;
  end

  assign ev_rise   = evt_lvl & ~evt_prev_q;
  assign ev_fall   = ~evt_lvl & evt_prev_q;
  assign gate_open = evt_lvl ^ gate_low;
  assign down_eff  = sw_down ^ (xdir_en & xdir_lvl);

  always_comb begin
    step = 1'b0;
    if (run) begin
      unique case (mode)
        MODE_TIMER: step = tick;
        MODE_GATED: step = tick & gate_open;
        MODE_EVENT: step = (rise_en & ev_rise) | (fall_en & ev_fall);
        MODE_CHAIN: step = chain_in;
        default:    step = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= !load && step && at_wrap(count_q, down_eff);
      if (load)      count_q <= load_val;
      else if (step) count_q <= step_count(count_q, down_eff);
    end
  end

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count_q));
  // R2
  timer_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TIMER && !tick && !load) |=> $stable(count_q));
  // R5
  event_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVENT && !ev_rise && !ev_fall && !load) |=> $stable(count_q));
  // R9
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CHAIN && !chain_in && !load) |=> $stable(count_q));
  // R7
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down_eff && count_q == '1 && !load) |=> (count_q == '0 && wrap_q));
  // R8
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down_eff && count_q == '0 && !load) |=> (count_q == '1 && wrap_q));
  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import tmr_pkg::*;
#(
  parameter int C_W = CNT_W,
  parameter int A_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [A_W-1:0] reg_addr,
  input  logic [C_W-1:0] reg_wdata,
  output logic [C_W-1:0] reg_rdata,
  input  logic           evt_in,
  input  logic           dir_in,
  input  logic           chain_in,
  output logic           wrap_pulse
);
  localparam logic [A_W-1:0] ADDR_CTRL  = A_W'(0);
  localparam logic [A_W-1:0] ADDR_COUNT = A_W'(1);

  ctrl_t          ctrl_q;
  logic           ps_tick;
  logic [1:0]     sync_lvl;
  logic [C_W-1:0] count;
  logic           load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
  end

  assign load = reg_wr && (reg_addr == ADDR_COUNT);

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata = ctrl_q;
      ADDR_COUNT: reg_rdata = count;
      default:    reg_rdata = '0;
    endcase
  end

  tmr_prescaler u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.run),
    .sel  (ctrl_q.ps_sel),
    .tick (ps_tick)
  );

  tmr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dir_in, evt_in}),
    .dout (sync_lvl)
  );

  tmr_core #(.C_W(C_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (ctrl_q.mode),
    .run     (ctrl_q.run),
    .sw_down (ctrl_q.down),
    .xdir_en (ctrl_q.xdir_en),
    .gate_low(ctrl_q.gate_low),
    .rise_en (ctrl_q.rise_en),
    .fall_en (ctrl_q.fall_en),
    .tick    (ps_tick),
    .evt_lvl (sync_lvl[0]),
    .xdir_lvl(sync_lvl[1]),
    .chain_in(chain_in),
    .load    (load),
    .load_val(reg_wdata),
    .count_q (count),
    .wrap_q  (wrap_pulse)
  );

  // R1
  wrap_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!wrap_pulse || rst_n));
endmodule

// File: tb/updn_timer_tb.sv
module updn_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        evt_in = 1'b0;
  logic        dir_in = 1'b0;
  logic        chain_in = 1'b0;
  logic        wrap_pulse;

  int checks = 0;
  int fails = 0;
  int wraps_seen = 0;
  bit done = 0;

  typedef struct {
    string       req;
    bit          is_wrap;
    logic [15:0] exp;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  updn_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .dir_in(dir_in), .chain_in(chain_in), .wrap_pulse(wrap_pulse)
  );

  always @(negedge clk) if (rst_n && wrap_pulse) wraps_seen++;

  // monitor: pops expectations and compares with the port values
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      act = it.is_wrap ? 16'(wraps_seen) : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", it.req,
                 it.is_wrap ? "wraps" : "count", act, it.exp);
      end
    end
  end

  task automatic exp_count(input string req, input logic [15:0] v);
    sb_q.push_back('{req, 1'b0, v});
  endtask

  task automatic exp_wraps(input string req, input int n);
    sb_q.push_back('{req, 1'b1, 16'(n)});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = 1'b1; wait_cyc(4);
      evt_in = 1'b0; wait_cyc(4);
    end
    wait_cyc(4);
  endtask

  task automatic chain_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      chain_in = 1'b1; wait_cyc(1);
      chain_in = 1'b0; wait_cyc(2);
    end
  endtask

  // control encodings
  localparam logic [15:0] RUN = 16'h0020, DOWN = 16'h0040, XDIR = 16'h0080;
  localparam logic [15:0] GLOW = 16'h0100, RISE = 16'h0200, FALL = 16'h0400;

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    exp_count("R1", 16'h0000);
    exp_wraps("R1", 0);
    wait_cyc(1);
    reg_addr = 2'd0;
    #1;
    checks++;
    if (reg_rdata !== 16'h0000) begin
      fails++;
      $display("FAIL R1 ctrl actual=%0h expected=0", reg_rdata);
    end
    reg_addr = 2'd1;

    // R10 load
    wr(2'd1, 16'h1234); exp_count("R10", 16'h1234);
    wr(2'd1, 16'h0000); exp_count("R10", 16'h0000);

    // R2 timer mode, divide by 8
    wr(2'd0, RUN);
    wait_cyc(39); exp_count("R2", 16'd4);
    wait_cyc(1);  exp_count("R2", 16'd5);
    wr(2'd0, 16'h0);
    // R3 stopped count holds
    wait_cyc(50); exp_count("R3", 16'd5);

    // R2 divide by 1024
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | (16'd7 << 2));
    wait_cyc(2047); exp_count("R2", 16'd1);
    wait_cyc(1);    exp_count("R2", 16'd2);
    wr(2'd0, 16'h0);

    // R6 software down
    wr(2'd1, 16'd3);
    wr(2'd0, RUN | DOWN);
    wait_cyc(16); exp_count("R6", 16'd1);
    wr(2'd0, 16'h0);

    // R8 down wrap
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | DOWN);
    wait_cyc(8); exp_count("R8", 16'hFFFF); exp_wraps("R8", 1);
    wr(2'd0, 16'h0);

    // R7 up wrap
    wr(2'd1, 16'hFFFF);
    wr(2'd0, RUN);
    wait_cyc(8); exp_count("R7", 16'h0000); exp_wraps("R7", 2);
    wr(2'd0, 16'h0);

    // R6 external direction
    dir_in = 1'b1;
    wr(2'd1, 16'd10);
    wr(2'd0, RUN | XDIR);
    wait_cyc(16); exp_count("R6", 16'd8);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd10);
    wr(2'd0, RUN);
    wait_cyc(8); exp_count("R6", 16'd11);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd10);
    wr(2'd0, RUN | DOWN | XDIR);
    wait_cyc(8); exp_count("R6", 16'd11);
    wr(2'd0, 16'h0);
    dir_in = 1'b0;

    // R4 gated mode
    wr(2'd1, 16'h0);
    evt_in = 1'b0;
    wr(2'd0, RUN | 16'd1);
    wait_cyc(64); exp_count("R4", 16'd0);
    wr(2'd0, 16'h0);
    evt_in = 1'b1;
    wr(2'd0, RUN | 16'd1);
    wait_cyc(24); exp_count("R4", 16'd3);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | GLOW | 16'd1);
    wait_cyc(24); exp_count("R4", 16'd0);
    wr(2'd0, 16'h0);
    evt_in = 1'b0;
    wr(2'd0, RUN | GLOW | 16'd1);
    wait_cyc(24); exp_count("R4", 16'd3);
    wr(2'd0, 16'h0);

    // R5 event mode
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | RISE | 16'd2);
    evt_pulses(3); exp_count("R5", 16'd3);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | FALL | 16'd2);
    evt_pulses(3); exp_count("R5", 16'd3);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | RISE | FALL | 16'd2);
    evt_pulses(3); exp_count("R5", 16'd6);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0);
    wr(2'd0, RUN | 16'd2);
    evt_pulses(3); exp_count("R5", 16'd0);
    wr(2'd0, 16'h0);

    // R9 chain mode across a wrap
    wr(2'd1, 16'hFFFE);
    wr(2'd0, RUN | 16'd3);
    chain_pulses(3);
    exp_count("R9", 16'd1); exp_wraps("R7", 3);
    wait_cyc(20); exp_count("R9", 16'd1);
    wr(2'd0, 16'h0);

    wait_cyc(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule